// File: doc/BRIEF.md
# Earliest-Error Recorder with Processor Interrupt

This block sits beside a set of queues in a crossbar. It keeps one sticky error register for each queue and records which error arrived first. Output queues and input queues can report different error kinds. While a recorded error is outstanding, the block holds an interrupt toward two processor ports. Error pulses come from the queues as vectors laid out like the register bits. Software reads and writes the registers through a simple single-cycle port. The reads are combinational from the address.

Queue `s` sits at byte address `s*8`. Output queues take sources `0..NUM_OQ-1` and input queues follow them. The earliest-error word sits at `NSRC*8`. Each register also has a clear address `0x100` above its read address. A write to a queue's read address injects a test error. It sets bits just as a hardware pulse would, and it takes part in earliest-error capture. The earliest-error word cannot be written. It is released only through its clear address. A correct handler clears the queue register first and the earliest-error word second.

Top module: `errcap_top`

## Requirements
- R1: After a synchronous reset, every queue register and the earliest-error word read 0, and both interrupt outputs are low.
- R2: A hardware error pulse on a defined bit sets that bit on the next clock edge. The bit then stays set with no further pulses until it is cleared through the clear address.
- R3: Only defined bit positions can ever be set. Output queues use 0x3333: invalid-select [1:0], overflow [5:4], underflow [9:8], tail timeout [13:12]. Input queues use 0x0033: overflow [1:0], deadlock timeout [5:4]. Pulses or writes on any other bit leave the register unchanged.
- R4: A write to a queue's clear address (read address + 0x100) clears exactly the set bits that are 1 in the write data. A hardware pulse on the same bit in the same cycle wins, and the bit stays set.
- R5: The earliest-error word holds type in [3:0], channel in [7:4], source in [11:8] and valid in bit 12. Type codes are 0 invalid-select, 1 overflow, 2 underflow, 3 tail timeout, 4 deadlock timeout. The channel is 0 for the low bit of a 2-bit field and 1 for the high bit.
- R6: Type, channel and source load only while valid is clear. Later errors do not change a captured word.
- R7: When several errors arrive in one cycle, the lowest-numbered source is captured. Within that source, the lowest set bit position is captured.
- R8: Writes to the earliest-error read address have no effect.
- R9: A software write to a queue read address sets the masked written bits. It is captured as an error exactly as a hardware pulse would be, which raises the interrupt.
- R10: Both interrupt outputs are always equal, and they are high whenever valid is set.
- R11: Clearing the queue register first and then the earliest-error word drops the interrupt. If the earliest-error word is cleared first, valid drops but the interrupt stays high until the capturing queue's register reads 0.
- R12: A write to the earliest-error clear address in a cycle that carries new errors captures the new error instead of leaving the word empty.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| oq_evt_i | input | NUM_OQ*16 | Error pulses from output queues, 16 bits per queue in register layout |
| iq_evt_i | input | NUM_IQ*16 | Error pulses from input queues, 16 bits per queue in register layout |
| reg_we_i | input | 1 | Register write strobe |
| reg_addr_i | input | ADDR_W | Byte address for reads and writes |
| reg_wdata_i | input | 16 | Write data |
| reg_rdata_o | output | 16 | Read data for the addressed register (0 at clear addresses) |
| irq_p0_o | output | 1 | Interrupt to processor port 0 |
| irq_p1_o | output | 1 | Interrupt to processor port 1 |

## Verification
The bench targets the two clear orders. A design that tied the interrupt to valid alone would drop it early when the earliest-error word is cleared first. A design that tracked only queue bits would keep it high after a correct clear. It also sends same-cycle errors across several sources and bits, where a wrong priority encoder records the wrong source or channel. It checks that an earliest-error clear arriving with a new error keeps the new error, which a clear-wins design would lose. It also checks that a hardware pulse survives a simultaneous clear, which a clear-wins register would drop silently.

// File: rtl/errcap_pkg.sv
package errcap_pkg;

    localparam int DW    = 16;
    localparam int SRC_W = 4;

    localparam logic [DW-1:0] OQ_MASK = 16'h3333;
    localparam logic [DW-1:0] IQ_MASK = 16'h0033;

    typedef enum logic [3:0] {
        ET_BADSEL = 4'd0,
        ET_OVF    = 4'd1,
        ET_UNF    = 4'd2,
        ET_TAILTO = 4'd3,
        ET_DLKTO  = 4'd4
    } err_type_e;

    // packed MSB first: valid at bit 12, source [11:8], channel [7:4], type [3:0]
    typedef struct packed {
        logic             vld;
        logic [SRC_W-1:0] src;
        logic [3:0]       chan;
        err_type_e        kind;
    } first_err_t;

    function automatic logic [DW-1:0] field_mask(input bit is_out);
        return is_out ? OQ_MASK : IQ_MASK;
    endfunction

    function automatic logic [3:0] lowest_set(input logic [DW-1:0] v);
        logic [3:0] idx;
        idx = '0;
        for (int i = DW - 1; i >= 0; i--) begin
            if (v[i]) idx = 4'(i);
        end
        return idx;
    endfunction

    function automatic err_type_e type_of_bit(input bit is_out, input logic [3:0] pos);
        if (is_out) begin
            case (pos[3:2])
                2'd0:    return ET_BADSEL;
                2'd1:    return ET_OVF;
                2'd2:    return ET_UNF;
                default: return ET_TAILTO;
            endcase
        end
        return pos[2] ? ET_DLKTO : ET_OVF;
    endfunction

endpackage

// File: rtl/errcap_qreg.sv
module errcap_qreg
    import errcap_pkg::*;
#(
    parameter bit IS_OUT = 1'b1
) (
    input  logic          clk,
    input  logic          rst,
    input  logic [DW-1:0] hw_evt,
    input  logic          inj_we,
    input  logic          clr_we,
    input  logic [DW-1:0] wdata,
    output logic [DW-1:0] q,
    output logic [DW-1:0] evt
);
    localparam logic [DW-1:0] MASK = field_mask(IS_OUT);

    logic [DW-1:0] clr_bits;

    always_comb begin
        evt      = (hw_evt | (inj_we ? wdata : '0)) & MASK;
        clr_bits = clr_we ? (wdata & MASK) : '0;
    end

    always_ff @(posedge clk) begin
        if (rst) q <= '0;
        else     q <= (q & ~clr_bits) | evt;
    end
endmodule

// File: rtl/errcap_first.sv
module errcap_first
    import errcap_pkg::*;
#(
    parameter int NUM_OQ = 4,
    parameter int NSRC   = 8
) (
    input  logic               clk,
    input  logic               rst,
    input  logic [NSRC*DW-1:0] evt,
    input  logic [NSRC-1:0]    q_nz,
    input  logic               fe_clr,
    output first_err_t         fe,
    output logic               irq
);
    logic             hit;
    logic             sel_out;
    logic [SRC_W-1:0] sel_src;
    logic [DW-1:0]    sel_vec;
    logic [3:0]       pos;
    first_err_t       cand;
    logic             linger;
    logic [SRC_W-1:0] lsrc;
    logic [15:0]      nz16;

    assign nz16 = 16'(q_nz);

    always_comb begin
        hit     = 1'b0;
        sel_out = 1'b0;
        sel_src = '0;
        sel_vec = '0;
        for (int s = NSRC - 1; s >= 0; s--) begin
            if (|evt[s*DW +: DW]) begin
                hit     = 1'b1;
                sel_src = SRC_W'(s);
                sel_vec = evt[s*DW +: DW];
                sel_out = (s < NUM_OQ);
            end
        end
        pos       = lowest_set(sel_vec);
        cand.vld  = 1'b1;
        cand.src  = sel_src;
        cand.chan = {3'b000, pos[0]};
        cand.kind = type_of_bit(sel_out, pos);
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            fe     <= '0;
            linger <= 1'b0;
            lsrc   <= '0;
        end else begin
            if (!fe.vld || fe_clr) fe <= hit ? cand : '0;
            if (fe_clr && fe.vld) begin
                linger <= 1'b1;
                lsrc   <= fe.src;
            end else if (!nz16[lsrc]) begin
                linger <= 1'b0;
            end
        end
    end

    assign irq = fe.vld | (linger & nz16[lsrc]);
endmodule

// File: rtl/errcap_top.sv
module errcap_top
    import errcap_pkg::*;
#(
    parameter int NUM_OQ = 4,
    parameter int NUM_IQ = 4,
    parameter int ADDR_W = 12
) (
    input  logic                 clk,
    input  logic                 rst,
    input  logic [NUM_OQ*16-1:0] oq_evt_i,
    input  logic [NUM_IQ*16-1:0] iq_evt_i,
    input  logic                 reg_we_i,
    input  logic [ADDR_W-1:0]    reg_addr_i,
    input  logic [15:0]          reg_wdata_i,
    output logic [15:0]          reg_rdata_o,
    output logic                 irq_p0_o,
    output logic                 irq_p1_o
);
    localparam int NSRC    = NUM_OQ + NUM_IQ;
    localparam int CLR_OFS = 'h100;
    localparam logic [ADDR_W-1:0] FE_A    = ADDR_W'(NSRC * 8);
    localparam logic [ADDR_W-1:0] FE_CL_A = ADDR_W'(CLR_OFS + NSRC * 8);

    logic [NSRC*DW-1:0] q_flat;
    logic [NSRC*DW-1:0] evt_flat;
    logic [NSRC-1:0]    q_nz;
    logic               fe_clr;
    first_err_t         fe;
    logic [12:0]        fe_word;
    logic               irq;

    assign fe_clr  = reg_we_i && (reg_addr_i == FE_CL_A);
    assign fe_word = fe;

    for (genvar s = 0; s < NSRC; s++) begin : g_q
        localparam logic [ADDR_W-1:0] RD_A = ADDR_W'(s * 8);
        localparam logic [ADDR_W-1:0] CL_A = ADDR_W'(CLR_OFS + s * 8);
        logic [DW-1:0] hw;
        logic [DW-1:0] qv;
        logic [DW-1:0] ev;
        if (s < NUM_OQ) begin : g_o
            assign hw = oq_evt_i[s*DW +: DW];
        end else begin : g_i
            assign hw = iq_evt_i[(s-NUM_OQ)*DW +: DW];
        end
        errcap_qreg #(.IS_OUT(s < NUM_OQ)) u_q (
            .clk    (clk),
            .rst    (rst),
            .hw_evt (hw),
            .inj_we (reg_we_i && (reg_addr_i == RD_A)),
            .clr_we (reg_we_i && (reg_addr_i == CL_A)),
            .wdata  (reg_wdata_i),
            .q      (qv),
            .evt    (ev)
        );
        assign q_flat[s*DW +: DW]   = qv;
        assign evt_flat[s*DW +: DW] = ev;
        assign q_nz[s]              = |qv;
    end

    errcap_first #(.NUM_OQ(NUM_OQ), .NSRC(NSRC)) u_first (
        .clk    (clk),
        .rst    (rst),
        .evt    (evt_flat),
        .q_nz   (q_nz),
        .fe_clr (fe_clr),
        .fe     (fe),
        .irq    (irq)
    );

    always_comb begin
        reg_rdata_o = '0;
        for (int s = 0; s < NSRC; s++) begin
            if (reg_addr_i == ADDR_W'(s * 8)) reg_rdata_o = q_flat[s*DW +: DW];
        end
        if (reg_addr_i == FE_A) reg_rdata_o = 16'(fe_word);
    end

    assign irq_p0_o = irq;
    assign irq_p1_o = irq;
endmodule

// File: rtl/errcap_chk.sv
module errcap_chk #(
    parameter int NUM_OQ = 4,
    parameter int NSRC   = 8
) (
    input logic               clk,
    input logic               rst,
    input logic               reg_we_i,
    input logic               fe_clr,
    input logic [12:0]        fe_word,
    input logic [NSRC*16-1:0] q_flat,
    input logic               irq_p0_o,
    input logic               irq_p1_o
);
    logic [NSRC*16-1:0] legal;
    always_comb begin
        for (int s = 0; s < NSRC; s++) begin
            legal[s*16 +: 16] = (s < NUM_OQ) ? 16'h3333 : 16'h0033;
        end
    end

    AST_IRQ_PAIR: assert property (@(posedge clk) disable iff (rst) irq_p0_o == irq_p1_o); // R10
    AST_VALID_IRQ: assert property (@(posedge clk) disable iff (rst) fe_word[12] |-> irq_p0_o); // R10
    AST_FE_HOLD: assert property (@(posedge clk) disable iff (rst) (fe_word[12] && !fe_clr) |=> $stable(fe_word)); // R6
    AST_STICKY: assert property (@(posedge clk) disable iff (rst) !reg_we_i |=> ((q_flat & $past(q_flat)) == $past(q_flat))); // R2
    AST_LEGAL_BITS: assert property (@(posedge clk) disable iff (rst) (q_flat & ~legal) == '0); // R3
    AST_IRQ_CAUSE: assert property (@(posedge clk) disable iff (rst) irq_p0_o |-> (fe_word[12] || (q_flat != '0))); // R11
endmodule

bind errcap_top errcap_chk #(.NUM_OQ(NUM_OQ), .NSRC(NSRC)) u_chk (
    .clk      (clk),
    .rst      (rst),
    .reg_we_i (reg_we_i),
    .fe_clr   (fe_clr),
    .fe_word  (fe_word),
    .q_flat   (q_flat),
    .irq_p0_o (irq_p0_o),
    .irq_p1_o (irq_p1_o)
);

// File: tb/errcap_top_tb.sv
`timescale 1ns/1ps
module errcap_top_tb;
    localparam int NOQ  = 4;
    localparam int NIQ  = 4;
    localparam int NS   = NOQ + NIQ;
    localparam int FEA  = NS * 8;
    localparam int CLR  = 'h100;

    logic            clk = 1'b0;
    logic            rst = 1'b1;
    logic [NOQ*16-1:0] oq = '0;
    logic [NIQ*16-1:0] iq = '0;
    logic            we = 1'b0;
    logic [11:0]     addr = '0;
    logic [15:0]     wd = '0;
    logic [15:0]     rdata;
    logic            irq0, irq1;

    int n_chk = 0;
    int n_bad = 0;
    int cyc   = 0;

    logic [15:0] mq [NS];
    logic        m_vld;
    logic [3:0]  m_type, m_ch, m_src;
    logic        lg;
    logic [3:0]  lsrc;

    always #2.5 clk = ~clk;

    errcap_top #(.NUM_OQ(NOQ), .NUM_IQ(NIQ), .ADDR_W(12)) u_dut (
        .clk(clk), .rst(rst), .oq_evt_i(oq), .iq_evt_i(iq),
        .reg_we_i(we), .reg_addr_i(addr), .reg_wdata_i(wd),
        .reg_rdata_o(rdata), .irq_p0_o(irq0), .irq_p1_o(irq1));

    function automatic logic [15:0] legal_of(int s);
        return (s < NOQ) ? 16'h3333 : 16'h0033;
    endfunction

    function automatic logic [3:0] kind_of(int s, int pos);
        if (s < NOQ) return 4'(pos / 4);       // 0 badsel,1 ovf,2 unf,3 tail
        return (pos >= 4) ? 4'd4 : 4'd1;       // 1 ovf, 4 deadlock
    endfunction

    function automatic logic [15:0] fe_exp();
        return {3'b000, m_vld, m_src, m_ch, m_type};
    endfunction

    task automatic chk(input logic [15:0] act, input logic [15:0] exp, input string req);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: actual %h expected %h at cycle %0d", req, act, exp, cyc);
        end
    endtask

    task automatic rd(input int a, output logic [15:0] v);
        addr = 12'(a);
        #0.1;
        v = rdata;
    endtask

    task automatic model_step();
        logic [15:0] ev [NS];
        logic [15:0] nq [NS];
        logic        feclr;
        bit          found;
        feclr = we && (int'(addr) == CLR + FEA);
        for (int s = 0; s < NS; s++) begin
            logic [15:0] hw;
            hw = (s < NOQ) ? oq[s*16 +: 16] : iq[(s-NOQ)*16 +: 16];
            ev[s] = (hw | ((we && int'(addr) == s*8) ? wd : 16'h0)) & legal_of(s);
            nq[s] = (mq[s] & ~((we && int'(addr) == CLR + s*8) ? (wd & legal_of(s)) : 16'h0)) | ev[s];
        end
        if (feclr && m_vld) begin
            lg = 1'b1; lsrc = m_src;
        end else if (mq[lsrc] == 16'h0) begin
            lg = 1'b0;
        end
        if (!m_vld || feclr) begin
            found = 0;
            m_vld = 0; m_src = 0; m_ch = 0; m_type = 0;
            for (int s = 0; s < NS && !found; s++) begin
                for (int p = 0; p < 16 && !found; p++) begin
                    if (ev[s][p]) begin
                        found = 1; m_vld = 1; m_src = 4'(s);
                        m_ch = 4'(p % 2); m_type = kind_of(s, p);
                    end
                end
            end
        end
        for (int s = 0; s < NS; s++) mq[s] = nq[s];
    endtask

    task automatic compare_all(input string tag);
        logic [15:0] v;
        logic        ex;
        ex = m_vld | (lg & (mq[lsrc] != 16'h0));
        chk({15'h0, irq0}, {15'h0, ex}, {tag, " irq0"});
        chk({15'h0, irq1}, {15'h0, ex}, {tag, " irq1 R10"});
        for (int s = 0; s < NS; s++) begin
            rd(s * 8, v);
            chk(v, mq[s], {tag, " qreg"});
        end
        rd(FEA, v);
        chk(v, fe_exp(), {tag, " first-error"});
    endtask

    task automatic step(input logic [NOQ*16-1:0] o, input logic [NIQ*16-1:0] i,
                        input logic w, input int a, input logic [15:0] d, input string tag);
        @(negedge clk);
        oq = o; iq = i; we = w; addr = 12'(a); wd = d;
        model_step();
        @(posedge clk);
        #1;
        we = 0; oq = '0; iq = '0;
        compare_all(tag);
    endtask

    function automatic logic [63:0] at(int q, logic [15:0] v);
        return 64'(v) << (q * 16);
    endfunction

    always @(posedge clk) begin
        cyc++;
        if (cyc > 100000) begin
            n_chk++; n_bad++;
            $display("FAIL watchdog: actual cycle %0d expected completion", cyc);
            $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
            $finish;
        end
    end

    initial begin
        logic [15:0] v;
        int unsigned seed;
        seed = 32'd1357;
        void'($urandom(seed));
        for (int s = 0; s < NS; s++) mq[s] = 0;
        m_vld = 0; m_src = 0; m_ch = 0; m_type = 0; lg = 0; lsrc = 0;
        repeat (3) @(posedge clk);
        #1 rst = 0;
        compare_all("R1");
        chk({15'h0, irq0}, 16'h0, "R1 irq after reset");

        // R2 / R5: output queue 2 overflow channel 1
        step(at(2, 16'h0020), '0, 0, 0, 0, "R2");
        rd(FEA, v); chk(v, 16'h1211, "R5 layout");
        chk({15'h0, irq0}, 16'h1, "R10 irq with valid");
        step('0, '0, 0, 0, 0, "R2 sticky");
        // R6: later errors do not overwrite
        step(at(0, 16'h0001), at(1, 16'h0010), 0, 0, 0, "R6");
        rd(FEA, v); chk(v, 16'h1211, "R6 hold");
        // R8: write to first-error address ignored
        step('0, '0, 1, FEA, 16'h0000, "R8");
        rd(FEA, v); chk(v, 16'h1211, "R8 read-only");
        // R3: undefined bits ignored
        step(at(3, 16'hCCCC), at(0, 16'hFF00), 0, 0, 0, "R3");
        rd(24, v); chk(v, 16'h0000, "R3 oq mask");
        rd(32, v); chk(v, 16'h0000, "R3 iq mask");
        // R11: first-error cleared first, irq stays
        step('0, '0, 1, CLR + FEA, 16'hFFFF, "R11 fe-first");
        chk({15'h0, irq0}, 16'h1, "R11 irq held");
        rd(FEA, v); chk(v, 16'h0000, "R11 valid dropped");
        step('0, '0, 1, CLR + 16, 16'h0020, "R11 queue clear");
        chk({15'h0, irq1}, 16'h0, "R11 irq released");
        // R4: W1C only matching bits
        step('0, '0, 1, CLR + 0, 16'h0002, "R4");
        rd(0, v); chk(v, 16'h0001, "R4 partial clear");
        step('0, '0, 1, CLR + 0, 16'h0001, "R4");
        rd(0, v); chk(v, 16'h0000, "R4 cleared");
        // R4 set wins; R5 input-queue overflow capture
        step('0, at(1, 16'h0001), 1, CLR + 40, 16'h0011, "R4 set-wins");
        rd(40, v); chk(v, 16'h0001, "R4 set wins");
        rd(FEA, v); chk(v, 16'h1501, "R5 iq overflow");
        // R11 correct order
        step('0, '0, 1, CLR + 40, 16'h0001, "R11 queue-first");
        chk({15'h0, irq0}, 16'h1, "R11 irq while valid");
        step('0, '0, 1, CLR + FEA, 16'h0000, "R11 then fe");
        chk({15'h0, irq0}, 16'h0, "R11 irq dropped");
        // R7 simultaneous
        step(at(3, 16'h1000) | at(1, 16'h0210), '0, 0, 0, 0, "R7");
        rd(FEA, v); chk(v, 16'h1101, "R7 lowest source and bit");
        // R12 clear with new error
        step('0, at(2, 16'h0020), 1, CLR + FEA, 16'h0, "R12");
        rd(FEA, v); chk(v, 16'h1614, "R12 new capture");
        // tidy up
        step('0, '0, 1, CLR + 8, 16'hFFFF, "R4");
        step('0, '0, 1, CLR + 24, 16'hFFFF, "R4");
        step('0, '0, 1, CLR + 48, 16'hFFFF, "R4");
        step('0, '0, 1, CLR + FEA, 16'hFFFF, "R11");
        chk({15'h0, irq0}, 16'h0, "R11 idle");
        // R9 injection
        step('0, '0, 1, 56, 16'hFF31, "R9");
        rd(56, v); chk(v, 16'h0031, "R9 masked inject");
        rd(FEA, v); chk(v, 16'h1701, "R9 captured");
        chk({15'h0, irq1}, 16'h1, "R9 irq");
        step('0, '0, 1, CLR + 56, 16'hFFFF, "R9");
        step('0, '0, 1, CLR + FEA, 16'hFFFF, "R9");
        // R5 invalid-select type 0, channel 1
        step(at(0, 16'h0002), '0, 0, 0, 0, "R5");
        rd(FEA, v); chk(v, 16'h1010, "R5 badsel");

        // random phase: R2,R4,R6,R7,R11 against the model
        for (int k = 0; k < 400; k++) begin
            logic [NOQ*16-1:0] ro;
            logic [NIQ*16-1:0] ri;
            logic rw;
            int   ra, pick;
            ro = '0; ri = '0;
            for (int q = 0; q < NOQ; q++) if ($urandom % 8 == 0) ro[q*16 +: 16] = 16'(1 << ($urandom % 16));
            for (int q = 0; q < NIQ; q++) if ($urandom % 8 == 0) ri[q*16 +: 16] = 16'(1 << ($urandom % 16));
            rw = ($urandom % 2 == 0);
            pick = $urandom % 6;
            if (pick == 0) ra = FEA;
            else if (pick == 1) ra = CLR + FEA;
            else if (pick == 2) ra = ($urandom % NS) * 8;
            else ra = CLR + ($urandom % NS) * 8;
            step(ro, ri, rw, ra, 16'($urandom), "R2,R4,R6,R7,R11 random");
        end

        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end
endmodule